// File: doc/BRIEF.md
# Buffer Membership Predictor Filter

This block is the membership predictor that a cache controller consults when a last-level miss has to be served while a DRAM victim buffer sits in front of persistent memory. The buffer controller reports every line it takes in (insert) and every line it writes out (remove). The cache controller presents the missing line address as a lookup. One cycle later the block returns a route decision for that lookup. A positive prediction means "read the DRAM buffer first, then memory if it misses". A negative prediction means "start the buffer read and the persistent memory read in parallel".

A prediction can be wrong in either direction, so every response also asks for the buffer to be checked. This keeps stale memory data from ever being returned. Two filter flavours are held in one cell array. In lazy-flush mode each cell acts as a single presence bit that only a clear pulse resets, and removals are ignored. In eager-flush mode each cell is a small saturating counter that removals decrement, so the filter tracks the few lines that are actually resident.

A two-state controller (ST_LAZY, ST_EAGER) picks the flavour. Its transitions are T_STAY (no change), T_CLEAR (lazy mode with clear asserted: wipe the cells and keep the running cycle's inserts), T_TO_EAGER and T_TO_LAZY (the mode input differs from the state: wipe the cells and discard that cycle's insert and remove events).

Top module: `bmp_filter`

## Requirements
- R1: Each cycle with lk_valid high produces exactly one response, with rt_valid high in the following cycle. rt_valid is low in every other cycle.
- R2: rt_check_buffer equals rt_valid in every cycle, so the buffer is consulted on every miss whatever the prediction.
- R3: rt_buffer_first is 1 for a positive prediction (serial, buffer first) and 0 for a negative one (buffer and memory in parallel). A lookup is positive when both of its cells are non-zero, using the cell state from before that cycle's updates.
- R4: For a 32-bit line address, cell index 0 is the XOR of address bytes [7:0] and [15:8], and cell index 1 is the XOR of bytes [23:16] and [31:24]. Two addresses with equal index pairs therefore get the same prediction.
- R5: A lookup in the same cycle as an insert of the same address is reported positive.
- R6: An inserted line is predicted positive on any later lookup until a remove, clear or mode switch affects its cells. There are no false negatives.
- R7: In lazy mode, remove events have no effect on any prediction.
- R8: In lazy mode, clear empties every cell. An insert in the same cycle as clear is kept.
- R9: In eager mode, an insert adds one and a remove subtracts one from each distinct cell that the address selects. A cell that both select changes only once. An insert and a remove of the same cell in one cycle cancel, and a zero cell is not decremented.
- R10: Eager cells are 4 bits wide. They stop at 15 and are never decremented once at 15.
- R11: In eager mode, clear has no effect.
- R12: When eager_mode differs from the current mode, all cells are wiped, that cycle's insert and remove are discarded, and the new mode applies from the next cycle.
- R13: Reset leaves rt_valid low, lazy mode selected and all cells empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eager_mode | input | 1 | 1 selects eager-flush counting mode, 0 selects lazy-flush bit mode |
| clear | input | 1 | Empties the filter in lazy mode; ignored in eager mode |
| ins_valid | input | 1 | A line entered the DRAM buffer |
| ins_addr | input | 32 | Line address of the insert |
| rem_valid | input | 1 | A line left the DRAM buffer |
| rem_addr | input | 32 | Line address of the remove |
| lk_valid | input | 1 | Miss lookup request |
| lk_addr | input | 32 | Line address of the lookup |
| rt_valid | output | 1 | Route decision valid (one cycle after lookup) |
| rt_buffer_first | output | 1 | 1 = buffer first then memory, 0 = parallel access |
| rt_check_buffer | output | 1 | The buffer must be checked for this miss |

## Verification
The assertions take for granted that the buffer controller reports only real movements. A remove names a line that is still counted in the filter, and no remove is issued in the cycle when a line is inserted. Without that, a shared cell can fall to zero and the no-false-negative property cannot hold. They also assume the mode input changes only while the buffer is empty. The stimulus issues removals only for addresses it inserted earlier. It keeps the single-cycle insert and remove of one address to the eager cancellation case, where no lookup is later checked with the no-false-negative property. It flips the mode only after the tested lines have been drained or wiped.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

    typedef enum logic {
        ST_LAZY  = 1'b0,
        ST_EAGER = 1'b1
    } bmp_state_e;

    typedef enum logic [1:0] {
        T_STAY     = 2'd0,
        T_CLEAR    = 2'd1,
        T_TO_EAGER = 2'd2,
        T_TO_LAZY  = 2'd3
    } bmp_trans_e;

    typedef enum logic {
        RT_PARALLEL  = 1'b0,
        RT_BUF_FIRST = 1'b1
    } bmp_route_e;

endpackage

// File: rtl/bmp_hash.sv
module bmp_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx0,
    output logic [IDX_W-1:0]  idx1
);
    localparam int HALF  = ADDR_W / 2;
    localparam int FOLDS = HALF / IDX_W;

    // Low half folds into index 0, high half into index 1: disjoint slices.
    always_comb begin
        idx0 = '0;
        idx1 = '0;
        for (int k = 0; k < FOLDS; k++) begin
            idx0 = idx0 ^ addr[k*IDX_W +: IDX_W];
            idx1 = idx1 ^ addr[HALF + k*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/bmp_ctrl.sv
module bmp_ctrl
    import bmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eager_mode,
    input  logic clear,
    output logic in_eager,
    output logic wipe_all,
    output logic evt_enable
);
    bmp_state_e state_q, state_d;
    bmp_trans_e trans;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LAZY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        trans   = T_STAY;
        unique case (state_q)
            ST_LAZY: begin
                if (eager_mode) begin
                    trans   = T_TO_EAGER;
                    state_d = ST_EAGER;
                end else if (clear) begin
                    trans = T_CLEAR;
                end
            end
            ST_EAGER: begin
                if (!eager_mode) begin
                    trans   = T_TO_LAZY;
                    state_d = ST_LAZY;
                end
            end
            default: begin
                trans   = T_STAY;
                state_d = ST_LAZY;
            end
        endcase
    end

    always_comb begin
        in_eager   = (state_q == ST_EAGER);
        wipe_all   = 1'b0;
        evt_enable = 1'b1;
        unique case (trans)
            T_STAY:     ;
            T_CLEAR:    wipe_all = 1'b1;
            T_TO_EAGER: begin wipe_all = 1'b1; evt_enable = 1'b0; end
            T_TO_LAZY:  begin wipe_all = 1'b1; evt_enable = 1'b0; end
            default:    ;
        endcase
    end
endmodule

// File: rtl/bmp_cell.sv
module bmp_cell #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             eager,
    input  logic             set,
    input  logic             drop,
    output logic             nonzero
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wipe) begin
            cnt_q <= set ? ONE : '0;
        end else if (eager) begin
            if (cnt_q != CMAX) begin
                if (set && !drop)
                    cnt_q <= cnt_q + ONE;
                else if (drop && !set && cnt_q != '0)
                    cnt_q <= cnt_q - ONE;
            end
        end else if (set) begin
            cnt_q <= ONE;
        end
    end

    assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/bmp_route.sv
module bmp_route
    import bmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_valid,
    input  logic hit0,
    input  logic hit1,
    input  logic bypass,
    output logic rt_valid,
    output logic rt_buffer_first,
    output logic rt_check_buffer
);
    bmp_route_e route_d;

    always_comb begin
        route_d = (hit0 && hit1) || bypass ? RT_BUF_FIRST : RT_PARALLEL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid        <= 1'b0;
            rt_buffer_first <= 1'b0;
            rt_check_buffer <= 1'b0;
        end else begin
            rt_valid        <= lk_valid;
            rt_buffer_first <= lk_valid && (route_d == RT_BUF_FIRST);
            rt_check_buffer <= lk_valid;
        end
    end
endmodule

// File: rtl/bmp_filter.sv
module bmp_filter #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eager_mode,
    input  logic              clear,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              rem_valid,
    input  logic [ADDR_W-1:0] rem_addr,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rt_valid,
    output logic              rt_buffer_first,
    output logic              rt_check_buffer
);
    localparam int CELLS = 1 << IDX_W;

    logic             in_eager, wipe_all, evt_enable;
    logic [IDX_W-1:0] ih0, ih1, rh0, rh1, lh0, lh1;
    logic [CELLS-1:0] cell_nz;
    logic             ins_ok, rem_ok;

    bmp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .eager_mode (eager_mode),
        .clear      (clear),
        .in_eager   (in_eager),
        .wipe_all   (wipe_all),
        .evt_enable (evt_enable)
    );

    bmp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_ins (.addr(ins_addr), .idx0(ih0), .idx1(ih1));
    bmp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_rem (.addr(rem_addr), .idx0(rh0), .idx1(rh1));
    bmp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_lk  (.addr(lk_addr),  .idx0(lh0), .idx1(lh1));

    assign ins_ok = ins_valid && evt_enable;
    assign rem_ok = rem_valid && evt_enable && in_eager;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        logic set_i, drop_i;
        assign set_i  = ins_ok && ((ih0 == IDX_W'(i)) || (ih1 == IDX_W'(i)));
        assign drop_i = rem_ok && ((rh0 == IDX_W'(i)) || (rh1 == IDX_W'(i)));
        bmp_cell #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wipe    (wipe_all),
            .eager   (in_eager),
            .set     (set_i),
            .drop    (drop_i),
            .nonzero (cell_nz[i])
        );
    end

    bmp_route u_route (
        .clk             (clk),
        .rst_n           (rst_n),
        .lk_valid        (lk_valid),
        .hit0            (cell_nz[lh0]),
        .hit1            (cell_nz[lh1]),
        .bypass          (ins_valid && (ins_addr == lk_addr)),
        .rt_valid        (rt_valid),
        .rt_buffer_first (rt_buffer_first),
        .rt_check_buffer (rt_check_buffer)
    );
endmodule

// File: rtl/bmp_filter_chk.sv
module bmp_filter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eager_mode,
    input logic              clear,
    input logic              ins_valid,
    input logic [ADDR_W-1:0] ins_addr,
    input logic              rem_valid,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rt_valid,
    input logic              rt_buffer_first,
    input logic              rt_check_buffer,
    input logic              in_eager,
    input logic              wipe_all
);
    // R1
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rt_valid);
    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rt_valid);
    // R2
    buffer_always_checked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_check_buffer == rt_valid);
    // R5
    insert_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ins_valid && lk_addr == ins_addr) |=> rt_buffer_first);
    // R6
    no_false_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !rem_valid && !wipe_all) ##1 (lk_valid && lk_addr == $past(ins_addr))
        |=> rt_buffer_first);
    // R8
    lazy_clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !in_eager && !ins_valid) ##1 (lk_valid && !ins_valid) |=> !rt_buffer_first);
    // R12
    mode_switch_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eager_mode != in_eager) ##1 (lk_valid && !ins_valid) |=> !rt_buffer_first);
    // R12
    mode_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eager_mode != in_eager) |=> (in_eager == $past(eager_mode)));
    // R13
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!rt_valid && !in_eager));
endmodule

bind bmp_filter bmp_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .eager_mode      (eager_mode),
    .clear           (clear),
    .ins_valid       (ins_valid),
    .ins_addr        (ins_addr),
    .rem_valid       (rem_valid),
    .lk_valid        (lk_valid),
    .lk_addr         (lk_addr),
    .rt_valid        (rt_valid),
    .rt_buffer_first (rt_buffer_first),
    .rt_check_buffer (rt_check_buffer),
    .in_eager        (in_eager),
    .wipe_all        (wipe_all)
);

// File: tb/sim_bmp_filter.sv
module sim_bmp_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eager_mode = 1'b0, clear = 1'b0;
    logic        ins_valid = 1'b0, rem_valid = 1'b0, lk_valid = 1'b0;
    logic [31:0] ins_addr = '0, rem_addr = '0, lk_addr = '0;
    logic        rt_valid, rt_buffer_first, rt_check_buffer;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cnt_m [256];
    bit mode_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmp_filter u0 (
        .clk(clk), .rst_n(rst_n), .eager_mode(eager_mode), .clear(clear),
        .ins_valid(ins_valid), .ins_addr(ins_addr),
        .rem_valid(rem_valid), .rem_addr(rem_addr),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rt_valid(rt_valid), .rt_buffer_first(rt_buffer_first),
        .rt_check_buffer(rt_check_buffer)
    );

    function automatic int hx0(input logic [31:0] a);
        return int'(a[7:0] ^ a[15:8]);
    endfunction
    function automatic int hx1(input logic [31:0] a);
        return int'(a[23:16] ^ a[31:24]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compute expectation, sample at next negedge.
    task automatic step(input bit iv, input logic [31:0] ia, input bit rv, input logic [31:0] ra,
                        input bit lv, input logic [31:0] la, input bit clr, input string tag);
        bit exp;
        int i0, i1, r0, r1;
        ins_valid = iv; ins_addr = ia; rem_valid = rv; rem_addr = ra;
        lk_valid = lv; lk_addr = la; clear = clr;
        exp = ((cnt_m[hx0(la)] != 0) && (cnt_m[hx1(la)] != 0)) || (iv && ia == la);
        i0 = hx0(ia); i1 = hx1(ia); r0 = hx0(ra); r1 = hx1(ra);
        if (eager_mode != mode_m) begin
            for (int c = 0; c < 256; c++) cnt_m[c] = 0;
            mode_m = eager_mode;
        end else if (!mode_m) begin
            if (clr) for (int c = 0; c < 256; c++) cnt_m[c] = 0;
            if (iv) begin cnt_m[i0] = 1; cnt_m[i1] = 1; end
        end else begin
            for (int c = 0; c < 256; c++) begin
                bit inc, dec;
                inc = iv && (c == i0 || c == i1);
                dec = rv && (c == r0 || c == r1);
                if (cnt_m[c] != 15) begin
                    if (inc && !dec) cnt_m[c]++;
                    else if (dec && !inc && cnt_m[c] > 0) cnt_m[c]--;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, int'(rt_valid), int'(lv));
        check("R2 check_buffer", int'(rt_check_buffer), int'(lv));
        if (lv) check(tag, int'(rt_buffer_first), int'(exp));
    endtask

    task automatic idle();
        step(0, '0, 0, '0, 0, '0, 0, "R1");
    endtask
    task automatic ins(input logic [31:0] a);
        step(1, a, 0, '0, 0, '0, 0, "R1");
    endtask
    task automatic rem(input logic [31:0] a);
        step(0, '0, 1, a, 0, '0, 0, "R1");
    endtask
    task automatic look(input logic [31:0] a, input string tag);
        step(0, '0, 0, '0, 1, a, 0, tag);
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'h9E37_79B9 * (k + 1) ^ (k << 11);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 256; c++) cnt_m[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13 reset rt_valid", int'(rt_valid), 0);
        rst_n = 1'b1;
        // R13: empty after reset
        for (int k = 0; k < 64; k++) look(pat(k), "R13");

        // Lazy sweep: insert 24 lines, then look up inserted, aliases and others (R3, R6)
        for (int k = 0; k < 24; k++) ins(pat(k));
        for (int k = 0; k < 24; k++) look(pat(k), "R6");
        for (int k = 0; k < 400; k++) look(pat(k + 100) ^ (k << 3), "R3");
        // R4: flipping bit 0 of every byte keeps both indices
        for (int k = 0; k < 24; k++) look(pat(k) ^ 32'h0101_0101, "R4");
        for (int k = 0; k < 24; k++) look(pat(k) ^ 32'h0000_0101 ^ 32'h0100_0000, "R4");
        // R7: removals ignored in lazy mode
        for (int k = 0; k < 24; k++) rem(pat(k));
        for (int k = 0; k < 24; k++) look(pat(k), "R7");
        // R8: clear empties, concurrent insert survives
        step(0, '0, 0, '0, 0, '0, 1, "R8");
        for (int k = 0; k < 24; k++) look(pat(k), "R8");
        step(1, 32'hCAFE_0042, 0, '0, 0, '0, 1, "R8");
        look(32'hCAFE_0042, "R8");
        look(32'h1234_5678, "R8");
        // R5: same-cycle insert bypass
        step(1, 32'h0BAD_F00D, 0, '0, 1, 32'h0BAD_F00D, 0, "R5");
        look(32'h0BAD_F00D, "R5");

        // R12: switch to eager wipes and drops the switch-cycle insert
        eager_mode = 1'b1;
        step(1, 32'h5555_AAAA, 0, '0, 1, 32'h0BAD_F00D, 0, "R12");
        look(32'h0BAD_F00D, "R12");
        look(32'h5555_AAAA, "R12");
        look(32'hCAFE_0042, "R12");

        // R9: counting inserts and removals
        ins(32'h0000_0011);
        look(32'h0000_0011, "R9");
        rem(32'h0000_0011);
        look(32'h0000_0011, "R9");
        ins(32'h0000_0011); ins(32'h0000_0011);
        rem(32'h0000_0011);
        look(32'h0000_0011, "R9");
        rem(32'h0000_0011);
        look(32'h0000_0011, "R9");
        rem(32'h0000_0011);
        ins(32'h0000_0011);
        look(32'h0000_0011, "R9");
        step(1, 32'h0000_0011, 1, 32'h0000_0011, 0, '0, 0, "R9");
        look(32'h0000_0011, "R9");
        rem(32'h0000_0011);
        look(32'h0000_0011, "R9");
        // R9: address with both indices on one cell
        ins(32'h0303_0303);
        look(32'h0303_0303, "R9");
        rem(32'h0303_0303);
        look(32'h0303_0303, "R9");
        // eager sweep
        for (int k = 0; k < 16; k++) ins(pat(k + 500));
        for (int k = 0; k < 8; k++) rem(pat(k + 500));
        for (int k = 0; k < 16; k++) look(pat(k + 500), "R9");
        for (int k = 0; k < 200; k++) look(pat(k + 900), "R3");
        for (int k = 8; k < 16; k++) rem(pat(k + 500));
        for (int k = 0; k < 16; k++) look(pat(k + 500), "R9");
        // R10: saturation holds the cell at 15
        for (int k = 0; k < 20; k++) ins(32'h0077_0044);
        for (int k = 0; k < 20; k++) rem(32'h0077_0044);
        look(32'h0077_0044, "R10");
        for (int k = 0; k < 14; k++) ins(32'h0066_0022);
        for (int k = 0; k < 14; k++) rem(32'h0066_0022);
        look(32'h0066_0022, "R10");
        // R11: clear ignored in eager mode
        step(0, '0, 0, '0, 0, '0, 1, "R11");
        look(32'h0077_0044, "R11");

        // R12: back to lazy wipes saturated cells
        eager_mode = 1'b0;
        idle();
        look(32'h0077_0044, "R12");
        ins(32'h0077_0044);
        look(32'h0077_0044, "R12");
        idle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule